// File: doc/BRIEF.md
# Hypervisor Interrupt Control Register Block

This block holds the per-hart control state that a hypervisor uses to route interrupts toward a guest. It stores the guest-interrupt delegation mask, the hypervisor-level interrupt enables, the per-guest external interrupt enables and the software-set virtual pending bits. It also presents a read-only view of the per-guest pending summary that an interrupt controller delivers. Software reaches all of this through a simple register port with an address, read and write strobes, write data and combinational read data.

Several pending bits are not stored. They are derived every cycle from stored state and live inputs. The supervisor guest-external bit is set when any guest pending bit meets its enable. The VS external bit merges a software-set bit, the guest pending bit chosen by a select index, and an external line. The VS timer bit merges a software-set bit with a timer request. The VS software pending bit in the pending register is an alias: writes to it land in the virtual pending register. The derived pending vector is also driven on a port for the downstream interrupt logic. Privilege checks, trap entry and priority selection sit outside this block.

The block has no sequencer. All stored state updates on the clock edge on which a write strobe is sampled. The only other register is a one-cycle access-error flag.

Top module: `hv_irq_csr`

## Requirements
- R1: The guest enable register (address 0x607) keeps bits GEILEN down to 1 as written. Bit 0 and every bit above GEILEN read 0 and ignore writes. With GEILEN = 0 the whole register reads 0.
- R2: The guest pending register (address 0xE12) reads the controller input masked to bits GEILEN down to 1, with all other positions 0. A write to it changes no stored state and raises the access-error flag.
- R3: The delegation register (address 0x603) stores only bits 2, 6 and 10. It also stores bit 13 when the delegation counter-overflow parameter is 1. All other bits read 0.
- R4: The hypervisor enable register (address 0x604) stores only bits 2, 6, 10 and 12. It also stores bit 13 when the enable counter-overflow parameter is 1. All other bits read 0.
- R5: The virtual pending register (address 0x645) stores only bits 2, 6 and 10, and all of them are 0 after reset.
- R6: Bit 12 of the pending register (address 0x608) and of the pending output is 1 exactly when the guest pending value and the guest enable register share a set bit.
- R7: Bit 10 of the pending register is the OR of three terms: virtual pending bit 10, the external VS line, and the guest pending bit at the position given by the select index. The indexed term is 0 for index 0 or an index above GEILEN, and guest enables do not gate it.
- R8: Bit 6 of the pending register is the OR of virtual pending bit 6 and the timer request. Writes to address 0x608 do not change it.
- R9: Bit 2 of the pending register always equals virtual pending bit 2. A write to address 0x608 copies write-data bit 2 into virtual pending bit 2 and changes no other stored bit.
- R10: A read or write at an address outside the six listed ones returns 0 and stores nothing. The access-error flag is high in the cycle after that access and only then.
- R11: After reset every stored register reads 0, the pending output is 0 with inputs low, and the access-error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_re | input | 1 | Read strobe |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational, 0 when csr_re is low |
| csr_illegal | output | 1 | Access-error flag, one cycle after a bad access |
| gext_pend_i | input | XLEN | Per-guest pending summary from the interrupt controller |
| guest_sel_i | input | $clog2(XLEN) | Guest index feeding the VS external term |
| vs_timer_req_i | input | 1 | VS-level timer request |
| vs_ext_irq_i | input | 1 | Other VS-level external interrupt line |
| hyp_pend_o | output | XLEN | Derived hypervisor pending vector |

## Verification
Derived pending bits depend on nothing but current state and inputs. They are due in the same cycle as the change, so the bench sets inputs on a falling edge and samples one time unit later. A write becomes visible on the read port one clock after the strobe. The bench therefore drives a write on one falling edge, drops it on the next, and reads afterwards. The access-error flag is registered and is due exactly one cycle after the offending access. The bench samples it on the falling edge that follows the strobe, and on the edge after that to confirm it has dropped.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;

    localparam logic [11:0] ADDR_DELEG = 12'h603;
    localparam logic [11:0] ADDR_IE    = 12'h604;
    localparam logic [11:0] ADDR_GEIE  = 12'h607;
    localparam logic [11:0] ADDR_PEND  = 12'h608;
    localparam logic [11:0] ADDR_VIP   = 12'h645;
    localparam logic [11:0] ADDR_GEIP  = 12'hE12;

    localparam int BIT_VS_SW  = 2;
    localparam int BIT_VS_TMR = 6;
    localparam int BIT_VS_EXT = 10;
    localparam int BIT_SG_EXT = 12;
    localparam int BIT_LCOF   = 13;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DELEG,
        SEL_IE,
        SEL_GEIE,
        SEL_PEND,
        SEL_VIP,
        SEL_GEIP
    } csr_sel_e;

    function automatic csr_sel_e decode_addr(input logic [11:0] a);
        csr_sel_e s;
        unique case (a)
            ADDR_DELEG: s = SEL_DELEG;
            ADDR_IE:    s = SEL_IE;
            ADDR_GEIE:  s = SEL_GEIE;
            ADDR_PEND:  s = SEL_PEND;
            ADDR_VIP:   s = SEL_VIP;
            ADDR_GEIP:  s = SEL_GEIP;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hv_irq_regs.sv
module hv_irq_regs
    import hv_irq_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit LCOF_DELEG = 1'b1,
    parameter bit LCOF_IE    = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] gei_mask,
    output logic [XLEN-1:0] deleg_q,
    output logic [XLEN-1:0] ie_q,
    output logic [XLEN-1:0] geie_q,
    output logic [XLEN-1:0] vip_q
);

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] VS_BITS =
        (ONE << BIT_VS_SW) | (ONE << BIT_VS_TMR) | (ONE << BIT_VS_EXT);
    localparam logic [XLEN-1:0] DELEG_MASK =
        VS_BITS | (LCOF_DELEG ? (ONE << BIT_LCOF) : '0);
    localparam logic [XLEN-1:0] IE_MASK =
        VS_BITS | (ONE << BIT_SG_EXT) | (LCOF_IE ? (ONE << BIT_LCOF) : '0);
    localparam logic [XLEN-1:0] VIP_MASK = VS_BITS;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deleg_q <= '0;
            ie_q    <= '0;
            geie_q  <= '0;
            vip_q   <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_DELEG: deleg_q <= wdata & DELEG_MASK;
                SEL_IE:    ie_q    <= wdata & IE_MASK;
                SEL_GEIE:  geie_q  <= wdata & gei_mask;
                SEL_VIP:   vip_q   <= wdata & VIP_MASK;
                SEL_PEND:  vip_q[BIT_VS_SW] <= wdata[BIT_VS_SW];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hv_irq_pend.sv
module hv_irq_pend
    import hv_irq_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SELW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] gext_pend_i,
    input  logic [XLEN-1:0] gei_mask,
    input  logic [XLEN-1:0] geie_q,
    input  logic [XLEN-1:0] vip_q,
    input  logic [SELW-1:0] guest_sel_i,
    input  logic            vs_timer_req_i,
    input  logic            vs_ext_irq_i,
    output logic [XLEN-1:0] geip,
    output logic [XLEN-1:0] hip
);

    logic picked;
    logic sg_any;

    always_comb begin
        geip   = gext_pend_i & gei_mask;
        picked = geip[guest_sel_i];
        sg_any = |(geip & geie_q);
        hip = '0;
        hip[BIT_VS_SW]  = vip_q[BIT_VS_SW];
        hip[BIT_VS_TMR] = vip_q[BIT_VS_TMR] | vs_timer_req_i;
        hip[BIT_VS_EXT] = vip_q[BIT_VS_EXT] | picked | vs_ext_irq_i;
        hip[BIT_SG_EXT] = sg_any;
    end

endmodule

// File: rtl/hv_irq_rdmux.sv
module hv_irq_rdmux
    import hv_irq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            re,
    input  logic            we,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] deleg_q,
    input  logic [XLEN-1:0] ie_q,
    input  logic [XLEN-1:0] geie_q,
    input  logic [XLEN-1:0] vip_q,
    input  logic [XLEN-1:0] hip,
    input  logic [XLEN-1:0] geip,
    output logic [XLEN-1:0] rdata,
    output logic            illegal_q
);

    logic illegal_d;

    always_comb begin
        rdata = '0;
        if (re) begin
            unique case (sel)
                SEL_DELEG: rdata = deleg_q;
                SEL_IE:    rdata = ie_q;
                SEL_GEIE:  rdata = geie_q;
                SEL_PEND:  rdata = hip;
                SEL_VIP:   rdata = vip_q;
                SEL_GEIP:  rdata = geip;
                default:   rdata = '0;
            endcase
        end
        illegal_d = ((re || we) && (sel == SEL_NONE)) ||
                    (we && (sel == SEL_GEIP));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= illegal_d;
    end

endmodule

// File: rtl/hv_irq_csr.sv
module hv_irq_csr
    import hv_irq_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int GEILEN     = 6,
    parameter bit LCOF_DELEG = 1'b1,
    parameter bit LCOF_IE    = 1'b1,
    localparam int SELW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic            csr_re,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic [XLEN-1:0] gext_pend_i,
    input  logic [SELW-1:0] guest_sel_i,
    input  logic            vs_timer_req_i,
    input  logic            vs_ext_irq_i,
    output logic [XLEN-1:0] hyp_pend_o
);

    csr_sel_e        sel;
    logic [XLEN-1:0] gei_mask;
    logic [XLEN-1:0] deleg_q, ie_q, geie_q, vip_q, geip, hip;

    assign sel = decode_addr(csr_addr);

    for (genvar i = 0; i < XLEN; i++) begin : g_gei_mask
        if (i >= 1 && i <= GEILEN) begin : g_on
            assign gei_mask[i] = 1'b1;
        end else begin : g_off
            assign gei_mask[i] = 1'b0;
        end
    end

    hv_irq_regs #(
        .XLEN(XLEN), .LCOF_DELEG(LCOF_DELEG), .LCOF_IE(LCOF_IE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .sel(sel), .wdata(csr_wdata),
        .gei_mask(gei_mask), .deleg_q(deleg_q), .ie_q(ie_q),
        .geie_q(geie_q), .vip_q(vip_q)
    );

    hv_irq_pend #(.XLEN(XLEN)) pend_i (
        .gext_pend_i(gext_pend_i), .gei_mask(gei_mask), .geie_q(geie_q),
        .vip_q(vip_q), .guest_sel_i(guest_sel_i),
        .vs_timer_req_i(vs_timer_req_i), .vs_ext_irq_i(vs_ext_irq_i),
        .geip(geip), .hip(hip)
    );

    hv_irq_rdmux #(.XLEN(XLEN)) rdmux_i (
        .clk(clk), .rst_n(rst_n), .re(csr_re), .we(csr_we), .sel(sel),
        .deleg_q(deleg_q), .ie_q(ie_q), .geie_q(geie_q), .vip_q(vip_q),
        .hip(hip), .geip(geip), .rdata(csr_rdata), .illegal_q(csr_illegal)
    );

    assign hyp_pend_o = hip;

endmodule

// File: rtl/hv_irq_csr_chk.sv
module hv_irq_csr_chk
    import hv_irq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [11:0]     csr_addr,
    input logic            csr_re,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] gext_pend_i,
    input logic            vs_timer_req_i,
    input logic            csr_illegal,
    input logic [XLEN-1:0] hyp_pend_o,
    input logic [XLEN-1:0] geie_q,
    input logic [XLEN-1:0] vip_q
);

    logic [XLEN-1:0] allowed;
    logic            known;

    always_comb begin
        for (int i = 0; i < XLEN; i++) allowed[i] = (i >= 1) && (i <= GEILEN);
        known = (csr_addr == ADDR_DELEG) || (csr_addr == ADDR_IE) ||
                (csr_addr == ADDR_GEIE)  || (csr_addr == ADDR_PEND) ||
                (csr_addr == ADDR_VIP)   || (csr_addr == ADDR_GEIP);
    end

    assert_geie_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (geie_q & ~allowed) == '0);

    assert_geip_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_GEIP) |=> ($stable(geie_q) && $stable(vip_q) && csr_illegal));

    assert_vip_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_VIP) |=>
        (vip_q[2] == $past(csr_wdata[2]) && vip_q[6] == $past(csr_wdata[6]) &&
         vip_q[10] == $past(csr_wdata[10])));

    assert_sgei_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_pend_o[12] == (|(gext_pend_i & geie_q)));

    assert_timer_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vs_timer_req_i |-> hyp_pend_o[6]);

    assert_alias_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_pend_o[2] == vip_q[2]);

    assert_alias_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADDR_PEND) |=>
        (vip_q[2] == $past(csr_wdata[2]) && vip_q[6] == $past(vip_q[6]) &&
         vip_q[10] == $past(vip_q[10])));

    assert_bad_addr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_re || csr_we) && !known) |=> csr_illegal);

    assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> $past(csr_re || csr_we));

endmodule

bind hv_irq_csr hv_irq_csr_chk #(.XLEN(XLEN), .GEILEN(GEILEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_re(csr_re),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .gext_pend_i(gext_pend_i),
    .vs_timer_req_i(vs_timer_req_i), .csr_illegal(csr_illegal),
    .hyp_pend_o(hyp_pend_o), .geie_q(geie_q), .vip_q(vip_q)
);

// File: tb/hv_irq_csr_tb_top.sv
`timescale 1ns/1ps
module hv_irq_csr_tb_top;

    localparam int XLEN = 64;
    localparam int G    = 6;
    localparam logic [63:0] GEIM  = ((64'd1 << (G + 1)) - 64'd1) & ~64'd1;
    localparam logic [63:0] VSM   = (64'd1 << 2) | (64'd1 << 6) | (64'd1 << 10);
    localparam logic [63:0] DELM  = VSM | (64'd1 << 13);
    localparam logic [63:0] IEM   = VSM | (64'd1 << 12) | (64'd1 << 13);
    localparam logic [11:0] A_DEL = 12'h603, A_IE = 12'h604, A_GEIE = 12'h607,
                            A_PEND = 12'h608, A_VIP = 12'h645, A_GEIP = 12'hE12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic csr_re = 1'b0, csr_we = 1'b0;
    logic [63:0] csr_wdata = '0, gext_pend_i = '0;
    logic [5:0] guest_sel_i = '0;
    logic vs_timer_req_i = 1'b0, vs_ext_irq_i = 1'b0;
    logic [63:0] csr_rdata, hyp_pend_o;
    logic csr_illegal;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    hv_irq_csr dut_i (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_re(csr_re),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .gext_pend_i(gext_pend_i),
        .guest_sel_i(guest_sel_i), .vs_timer_req_i(vs_timer_req_i),
        .vs_ext_irq_i(vs_ext_irq_i), .hyp_pend_o(hyp_pend_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write: strobe on one falling edge, drop on the next; flag sampled there
    task automatic wr(input logic [11:0] a, input logic [63:0] d, output logic flag);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        flag = csr_illegal;
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v, output logic flag);
        @(negedge clk);
        csr_addr = a; csr_re = 1'b1;
        #1 v = csr_rdata;
        @(negedge clk);
        flag = csr_illegal;
        csr_re = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic f;
        logic [11:0] regs [4] = '{A_DEL, A_IE, A_GEIE, A_VIP};
        logic [63:0] msks [4] = '{DELM, IEM, GEIM, VSM};
        logic [11:0] bad [3]  = '{12'h000, 12'h605, 12'hFFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        foreach (regs[k]) begin
            rd(regs[k], v, f);
            chk("R11 reset value", v, 64'd0);
        end
        rd(A_PEND, v, f); chk("R11 reset pend", v, 64'd0);
        chk("R11 pend output", hyp_pend_o, 64'd0);
        chk("R11 flag low", {63'd0, csr_illegal}, 64'd0);

        // R1 R3 R4 R5 walking-one and all-ones write masks
        foreach (regs[k]) begin
            for (int b = 0; b < 64; b++) begin
                wr(regs[k], 64'd1 << b, f);
                rd(regs[k], v, f);
                chk("R1/R3/R4/R5 walking mask", v, msks[k] & (64'd1 << b));
            end
            wr(regs[k], '1, f);
            rd(regs[k], v, f);
            chk("R1/R3/R4/R5 all ones", v, msks[k]);
            wr(regs[k], '0, f);
        end

        // R2 guest pending readback and write rejection
        for (int b = 0; b < 64; b++) begin
            gext_pend_i = 64'd1 << b;
            rd(A_GEIP, v, f);
            chk("R2 pending mirror", v, GEIM & (64'd1 << b));
        end
        wr(A_GEIE, 64'h2A, f);
        wr(A_GEIP, '1, f);
        chk("R2 write flags", {63'd0, f}, 64'd1);
        rd(A_GEIE, v, f); chk("R2 enable untouched", v, 64'h2A);
        rd(A_VIP, v, f);  chk("R2 vip untouched", v, 64'd0);
        wr(A_GEIE, '0, f);

        // R6 AND-reduce sweep
        for (int ge = 0; ge < 128; ge++) begin
            wr(A_GEIE, 64'(ge), f);
            for (int gp = 0; gp < 128; gp++) begin
                @(negedge clk);
                gext_pend_i = 64'(gp) | (64'hF << 60);
                #1 chk("R6 guest summary", {63'd0, hyp_pend_o[12]},
                       {63'd0, ((ge & gp & 32'h7E) != 0)});
            end
        end
        wr(A_GEIE, '0, f);

        // R7 indexed term, ungated by enables
        for (int s = 0; s < 64; s++) begin
            for (int p = 0; p < 2; p++) begin
                @(negedge clk);
                guest_sel_i = 6'(s);
                gext_pend_i = (p == 0) ? '1 : ~(64'd1 << s);
                #1 chk("R7 indexed guest", {63'd0, hyp_pend_o[10]},
                       {63'd0, (p == 0) && s >= 1 && s <= G});
            end
        end
        @(negedge clk); gext_pend_i = '0; guest_sel_i = '0;
        vs_ext_irq_i = 1'b1;
        #1 chk("R7 external line", {63'd0, hyp_pend_o[10]}, 64'd1);
        @(negedge clk); vs_ext_irq_i = 1'b0;
        wr(A_VIP, 64'd1 << 10, f);
        rd(A_PEND, v, f); chk("R7 virtual term", v, 64'd1 << 10);
        wr(A_VIP, '0, f);

        // R8 timer OR, not writable through pending
        for (int c = 0; c < 4; c++) begin
            wr(A_VIP, (c & 1) ? (64'd1 << 6) : 64'd0, f);
            @(negedge clk); vs_timer_req_i = (c & 2) != 0;
            #1 chk("R8 timer or", {63'd0, hyp_pend_o[6]}, {63'd0, c != 0});
        end
        @(negedge clk); vs_timer_req_i = 1'b0;
        wr(A_VIP, '0, f);
        wr(A_PEND, 64'd1 << 6, f);
        rd(A_PEND, v, f); chk("R8 write ignored", v, 64'd0);

        // R9 alias write lands in virtual pending
        wr(A_PEND, '1, f);
        rd(A_VIP, v, f);  chk("R9 alias set", v, 64'd1 << 2);
        rd(A_PEND, v, f); chk("R9 alias read", v, 64'd1 << 2);
        wr(A_VIP, VSM, f);
        wr(A_PEND, 64'd0, f);
        rd(A_VIP, v, f);  chk("R9 alias clear only bit", v, VSM & ~(64'd1 << 2));
        wr(A_VIP, '0, f);

        // R10 undefined addresses
        foreach (bad[k]) begin
            rd(bad[k], v, f);
            chk("R10 read zero", v, 64'd0);
            chk("R10 flag raised", {63'd0, f}, 64'd1);
            @(negedge clk);
            chk("R10 flag one cycle", {63'd0, csr_illegal}, 64'd0);
            wr(bad[k], '1, f);
            chk("R10 write flag", {63'd0, f}, 64'd1);
        end
        foreach (regs[k]) begin
            rd(regs[k], v, f);
            chk("R10 no store", v, 64'd0);
            chk("R10 legal no flag", {63'd0, f}, 64'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule